// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller serving up to 32 pins. Software reaches it through a simple register bus made of a write strobe, a read strobe, a byte address and 32-bit write and read data. It holds the output levels and the per-pin output enables. The output levels can be written whole, or changed bit by bit through separate set and clear registers, so no read-modify-write is needed.

Every pin input passes through a two-flop synchronizer. The synchronized level is readable and feeds a per-pin event detector. Three configuration bits per pin choose the trigger: a sense-kind bit picks edge or level, a polarity bit picks the active direction or level, and an any-edge bit makes both transitions count. Edge events latch into a sticky status bit, which is cleared by writing a one to the clear register. Level status follows the pin while it is active. Status, enable and mask are combined into one interrupt line.

Pull-enable, pull-kind, debounce-enable and debounce-prescale registers are plain read/write storage. They are meant for pad logic outside this block and change nothing inside it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_out` and `pin_oe` are 0 and `irq` is 0.
- R2: The direction register (offset 0x08) drives `pin_oe` directly: bit value 1 makes the pin an output and 0 makes it an input. It reads back as written.
- R3: The output register (0x00) drives `pin_out`. A write to 0x10 sets every output bit that is 1 in the write data. A write to 0x14 clears every output bit that is 1 in the write data. Bits that are 0 in either write keep their value, and both of these offsets read as 0.
- R4: Offset 0x04 reads the pin levels after the two-flop synchronizer, bit i for pin i.
- R5: With sense-kind 0 (0x34), any-edge 0 (0x38) and polarity 0 (0x3C), a 0→1 pin transition sets the pin's status bit (0x24) and a 1→0 transition does not.
- R6: With sense-kind 0, any-edge 0 and polarity 1, only a 1→0 transition sets the status bit.
- R7: With sense-kind 0 and any-edge 1, both transitions set the status bit, whatever the polarity.
- R8: With sense-kind 1, the status bit is 1 while the synchronized pin equals NOT polarity (polarity 0 means active-high, 1 means active-low). It is 0 otherwise, and a clear write does not drop it while the level is active.
- R9: An edge status bit stays set until a one is written to its bit of the clear register (0x30). Zero bits of that write leave the other status bits unchanged.
- R10: If a clear write and a new qualifying edge on the same pin land in the same cycle, the status bit stays set.
- R11: `irq` is high exactly when some pin has status 1, enable (0x20) 1 and mask (0x2C) 0.
- R12: Read data appears on `rdata` one cycle after `rd_en`. Unmapped offsets (such as 0x0C, 0x28 and 0x48) read as 0.
- R13: Pull-enable (0x18), pull-kind (0x1C), debounce-enable (0x40) and debounce-prescale (0x44) read back as written and do not change `pin_out` or `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 7 | Byte address in the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `addr` and `wdata` are defined in every cycle where a strobe is high, and that a single access occupies one cycle. The stimulus drives every bus field at the falling clock edge and holds it across exactly one rising edge. The sticky-status property assumes that the sense-kind configuration changes only through an observable bus write. The bench therefore reconfigures triggers only with explicit writes, and it holds each pin level for several cycles so that the synchronizer and the detector settle before a status read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Byte offsets decoded by software drivers
    localparam logic [7:0] OFS_DOUT = 8'h00;
    localparam logic [7:0] OFS_DIN  = 8'h04;
    localparam logic [7:0] OFS_DIR  = 8'h08;
    localparam logic [7:0] OFS_DSET = 8'h10;
    localparam logic [7:0] OFS_DCLR = 8'h14;
    localparam logic [7:0] OFS_PEN  = 8'h18;
    localparam logic [7:0] OFS_PTYP = 8'h1C;
    localparam logic [7:0] OFS_IEN  = 8'h20;
    localparam logic [7:0] OFS_IST  = 8'h24;
    localparam logic [7:0] OFS_IMSK = 8'h2C;
    localparam logic [7:0] OFS_ICLR = 8'h30;
    localparam logic [7:0] OFS_TTYP = 8'h34;
    localparam logic [7:0] OFS_BOTH = 8'h38;
    localparam logic [7:0] OFS_TLVL = 8'h3C;
    localparam logic [7:0] OFS_DBEN = 8'h40;
    localparam logic [7:0] OFS_DBPS = 8'h44;

    typedef enum logic [1:0] {
        TRIG_RISE,
        TRIG_FALL,
        TRIG_ANY,
        TRIG_LEVEL
    } trig_kind_e;

endpackage

// File: rtl/gpio_pin_sync.sv
// Two synchronizing flops plus one history flop for edge comparison.
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] now_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = raw_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign now_o  = sy_q.s2;
    assign prev_o = sy_q.s3;

endmodule

// File: rtl/gpio_evt_cell.sv
// Per-pin trigger decode and status bit.
module gpio_evt_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_now,
    input  logic lvl_prev,
    input  logic sense_lvl,
    input  logic pol,
    input  logic any_edge,
    input  logic clr,
    output logic st_o
);

    trig_kind_e kind;
    logic       hit;
    logic       st_d, st_q;

    always_comb begin
        if (sense_lvl)     kind = TRIG_LEVEL;
        else if (any_edge) kind = TRIG_ANY;
        else if (pol)      kind = TRIG_FALL;
        else               kind = TRIG_RISE;

        unique case (kind)
            TRIG_RISE:  hit = lvl_now & ~lvl_prev;
            TRIG_FALL:  hit = ~lvl_now & lvl_prev;
            TRIG_ANY:   hit = lvl_now ^ lvl_prev;
            default:    hit = lvl_now ^ pol;
        endcase

        // level status tracks the pin; edge status is sticky, new edge beats clear
        if (kind == TRIG_LEVEL) st_d = hit;
        else                    st_d = hit | (st_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int N = NUM_PINS;

    typedef struct packed {
        logic [N-1:0]      dout;
        logic [N-1:0]      dir;
        logic [N-1:0]      pen;
        logic [N-1:0]      ptyp;
        logic [N-1:0]      ien;
        logic [N-1:0]      imsk;
        logic [N-1:0]      ttyp;
        logic [N-1:0]      both;
        logic [N-1:0]      tlvl;
        logic [N-1:0]      dben;
        logic [DATA_W-1:0] dbps;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [N-1:0] lvl_now, lvl_prev, evt_st, iclr_vec;
    logic [N-1:0] wpins;
    logic [DATA_W-1:0] rmux;

    assign wpins = wdata[N-1:0];

    gpio_pin_sync #(.W(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .now_o  (lvl_now),
        .prev_o (lvl_prev)
    );

    assign iclr_vec = (wr_en && addr == ADDR_W'(OFS_ICLR)) ? wpins : '0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_evt
            gpio_evt_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .lvl_now   (lvl_now[i]),
                .lvl_prev  (lvl_prev[i]),
                .sense_lvl (r_q.ttyp[i]),
                .pol       (r_q.tlvl[i]),
                .any_edge  (r_q.both[i]),
                .clr       (iclr_vec[i]),
                .st_o      (evt_st[i])
            );
        end
    endgenerate

    always_comb begin
        unique case (addr)
            ADDR_W'(OFS_DOUT): rmux = DATA_W'(r_q.dout);
            ADDR_W'(OFS_DIN):  rmux = DATA_W'(lvl_now);
            ADDR_W'(OFS_DIR):  rmux = DATA_W'(r_q.dir);
            ADDR_W'(OFS_PEN):  rmux = DATA_W'(r_q.pen);
            ADDR_W'(OFS_PTYP): rmux = DATA_W'(r_q.ptyp);
            ADDR_W'(OFS_IEN):  rmux = DATA_W'(r_q.ien);
            ADDR_W'(OFS_IST):  rmux = DATA_W'(evt_st);
            ADDR_W'(OFS_IMSK): rmux = DATA_W'(r_q.imsk);
            ADDR_W'(OFS_TTYP): rmux = DATA_W'(r_q.ttyp);
            ADDR_W'(OFS_BOTH): rmux = DATA_W'(r_q.both);
            ADDR_W'(OFS_TLVL): rmux = DATA_W'(r_q.tlvl);
            ADDR_W'(OFS_DBEN): rmux = DATA_W'(r_q.dben);
            ADDR_W'(OFS_DBPS): rmux = r_q.dbps;
            default:           rmux = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (addr)
                ADDR_W'(OFS_DOUT): r_d.dout = wpins;
                ADDR_W'(OFS_DIR):  r_d.dir  = wpins;
                ADDR_W'(OFS_DSET): r_d.dout = r_q.dout | wpins;
                ADDR_W'(OFS_DCLR): r_d.dout = r_q.dout & ~wpins;
                ADDR_W'(OFS_PEN):  r_d.pen  = wpins;
                ADDR_W'(OFS_PTYP): r_d.ptyp = wpins;
                ADDR_W'(OFS_IEN):  r_d.ien  = wpins;
                ADDR_W'(OFS_IMSK): r_d.imsk = wpins;
                ADDR_W'(OFS_TTYP): r_d.ttyp = wpins;
                ADDR_W'(OFS_BOTH): r_d.both = wpins;
                ADDR_W'(OFS_TLVL): r_d.tlvl = wpins;
                ADDR_W'(OFS_DBEN): r_d.dben = wpins;
                ADDR_W'(OFS_DBPS): r_d.dbps = wdata;
                default: ;
            endcase
        end
        if (rd_en) r_d.rdata = rmux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata   = r_q.rdata;
    assign pin_out = r_q.dout;
    assign pin_oe  = r_q.dir;
    assign irq     = |(evt_st & r_q.ien & ~r_q.imsk);

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [N-1:0]      pin_out,
    input logic [N-1:0]      pin_oe,
    input logic              irq,
    input logic [N-1:0]      en_q,
    input logic [N-1:0]      msk_q,
    input logic [N-1:0]      ttyp_q,
    input logic [N-1:0]      st_q
);

    // R2
    dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DIR)) |=> pin_oe == $past(wdata[N-1:0]));

    // R3
    dset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DSET)) |=>
            (pin_out & $past(wdata[N-1:0])) == $past(wdata[N-1:0]));

    // R3
    dclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DCLR)) |=> (pin_out & $past(wdata[N-1:0])) == '0);

    // R12
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == ADDR_W'(8'h0C) || addr == ADDR_W'(8'h28))) |=> rdata == '0);

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((en_q & ~msk_q) != '0 && st_q != '0));

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == ADDR_W'(OFS_ICLR) || addr == ADDR_W'(OFS_TTYP))) |=>
            ((st_q & ~ttyp_q) & $past(st_q & ~ttyp_q)) == $past(st_q & ~ttyp_q));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .N      (NUM_PINS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .en_q    (r_q.ien),
    .msk_q   (r_q.imsk),
    .ttyp_q  (r_q.ttyp),
    .st_q    (evt_st)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    import gpio_irq_pkg::*;

    localparam int N  = 32;
    localparam int AW = 7;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [N-1:0]  pins = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pins), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    int errs = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a[AW-1:0]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        rd_en = 1'b1; addr = a[AW-1:0];
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // monitor: compares read data the cycle after each accepted read
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    chk("scoreboard underflow", 32'h1, 32'h0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk(it.tag, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq", irq, 0);
        rd(OFS_DOUT, 0, "R1 dout");
        rd(OFS_DIR, 0, "R1 dir");
        rd(OFS_IST, 0, "R1 status");
        rd(OFS_DBPS, 0, "R1 prescale");

        // R2 direction
        wr(OFS_DIR, 32'hF0F0_0F0F);
        chk("R2 pin_oe", pin_oe, 32'hF0F0_0F0F);
        rd(OFS_DIR, 32'hF0F0_0F0F, "R2 dir readback");

        // R3 output write, set, clear
        wr(OFS_DOUT, 32'h0000_00FF);
        chk("R3 dout write", pin_out, 32'h0000_00FF);
        wr(OFS_DSET, 32'h0000_FF00);
        chk("R3 set", pin_out, 32'h0000_FFFF);
        wr(OFS_DCLR, 32'h0000_000F);
        chk("R3 clear", pin_out, 32'h0000_FFF0);
        rd(OFS_DSET, 0, "R3 set reads zero");
        rd(OFS_DCLR, 0, "R3 clear reads zero");

        // R4 input sampling, R5 rising edges
        pins = 32'hA5A5_5A5A;
        settle();
        rd(OFS_DIN, 32'hA5A5_5A5A, "R4 input levels");
        rd(OFS_IST, 32'hA5A5_5A5A, "R5 rising status");
        wr(OFS_ICLR, 32'hFFFF_FFFF);
        pins = '0;
        settle();
        rd(OFS_IST, 0, "R5 falling ignored");
        rd(OFS_DIN, 0, "R4 input low");

        // R6 falling edge on pin 1
        wr(OFS_TLVL, 32'h2);
        pins[1] = 1'b1; settle();
        rd(OFS_IST, 0, "R6 rise ignored");
        pins[1] = 1'b0; settle();
        rd(OFS_IST, 32'h2, "R6 fall latched");
        wr(OFS_ICLR, 32'h2);

        // R7 both edges on pin 2
        wr(OFS_BOTH, 32'h4);
        pins[2] = 1'b1; settle();
        rd(OFS_IST, 32'h4, "R7 rise latched");
        wr(OFS_ICLR, 32'h4);
        pins[2] = 1'b0; settle();
        rd(OFS_IST, 32'h4, "R7 fall latched");
        wr(OFS_ICLR, 32'h4);

        // R9 partial clear
        pins[5:4] = 2'b11; settle();
        rd(OFS_IST, 32'h30, "R9 two pending");
        wr(OFS_ICLR, 32'h10);
        rd(OFS_IST, 32'h20, "R9 partial clear");
        wr(OFS_ICLR, 32'h20);

        // R11 interrupt combine on pin 6
        wr(OFS_IEN, 32'h40);
        chk("R11 idle irq", irq, 0);
        pins[6] = 1'b1; settle();
        chk("R11 irq raised", irq, 1);
        wr(OFS_IMSK, 32'h40);
        chk("R11 masked", irq, 0);
        wr(OFS_IMSK, 32'h0);
        chk("R11 unmasked", irq, 1);
        wr(OFS_IEN, 32'h0);
        chk("R11 disabled", irq, 0);
        wr(OFS_ICLR, 32'h40);

        // R8 level high on pin 8, then level low on pin 9
        wr(OFS_TTYP, 32'h100);
        settle();
        rd(OFS_IST, 0, "R8 high inactive");
        pins[8] = 1'b1; settle();
        rd(OFS_IST, 32'h100, "R8 high active");
        wr(OFS_ICLR, 32'h100);
        rd(OFS_IST, 32'h100, "R8 clear ignored");
        pins[8] = 1'b0; settle();
        rd(OFS_IST, 0, "R8 high released");
        wr(OFS_TTYP, 32'h300);
        wr(OFS_TLVL, 32'h202);
        settle();
        rd(OFS_IST, 32'h200, "R8 low active");
        pins[9] = 1'b1; settle();
        rd(OFS_IST, 0, "R8 low released");

        // R10 clear and new edge collide on pin 3
        wr(OFS_BOTH, 32'h0C);
        pins[3] = 1'b1; settle();
        rd(OFS_IST, 32'h8, "R10 setup");
        pins[3] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr(OFS_ICLR, 32'h8);
        rd(OFS_IST, 32'h8, "R10 edge beats clear");
        wr(OFS_ICLR, 32'h8);
        rd(OFS_IST, 0, "R9 clear after collision");

        // R12 unmapped offsets
        rd(8'h0C, 0, "R12 hole 0x0C");
        rd(8'h28, 0, "R12 hole 0x28");
        rd(8'h48, 0, "R12 past window");
        rd(OFS_ICLR, 0, "R12 clear reg reads zero");

        // R13 storage-only registers
        wr(OFS_PEN, 32'h0000_1234);
        wr(OFS_PTYP, 32'h00FF_00FF);
        wr(OFS_DBEN, 32'h0000_000F);
        wr(OFS_DBPS, 32'hDEAD_BEEF);
        rd(OFS_PEN, 32'h0000_1234, "R13 pull enable");
        rd(OFS_PTYP, 32'h00FF_00FF, "R13 pull kind");
        rd(OFS_DBEN, 32'h0000_000F, "R13 debounce enable");
        rd(OFS_DBPS, 32'hDEAD_BEEF, "R13 prescale");
        chk("R13 pin_out untouched", pin_out, 32'h0000_FFF0);
        chk("R13 pin_oe untouched", pin_oe, 32'hF0F0_0F0F);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", sb.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule